// File: doc/BRIEF.md
# Kernel Launch Warp Sequencer

This block turns a one-dimensional compute launch into a sequence of warp descriptors for a downstream dispatcher. A single start pulse carries an element count `n`. The block latches `n` and works out how many fixed-size thread blocks of 512 threads the launch needs, rounding up. It then walks the blocks in ascending order and splits each block into sixteen warps of 32 consecutive threads.

For each warp the block presents four fields: the block number, the warp number inside the block, the global index of the warp's first thread (block × 512 + warp × 32), and a 32-lane activity mask. The mask switches off every lane whose global index is `n` or more, so partial tail warps and partial tail blocks come out correctly. A warp whose mask would be empty is never sent. Descriptors leave through a valid/ready handshake. A one-cycle done pulse closes the launch.

The controller is a three-state machine. In **IDLE** it waits for a start. The transition *launch* goes from IDLE to ISSUE when start arrives with `n > 0`. The transition *empty launch* goes from IDLE straight to FINISH when `n = 0`. In **ISSUE** the machine holds the current descriptor valid. The transition *advance* stays in ISSUE on each accepted descriptor that is not the last. The transition *last accept* goes to FINISH when the final descriptor is taken. **FINISH** lasts one cycle, raises done, and always goes back to IDLE through the transition *retire*.

Top module: `kl_warp_seq`

## Requirements
- R1: After reset, `desc_valid_o` and `done_o` are low and `num_blocks_o` is zero.
- R2: An accepted start latches `n_i`. From the next cycle, `num_blocks_o` equals ceil(n/512) and holds until the next accepted start.
- R3: Descriptors come out in ascending block order, with warp numbers 0 to 15 in ascending order inside each block. The descriptor with flat index k has block k/16 and warp k%16.
- R4: `desc_base_o` equals block × 512 + warp × 32.
- R5: Bit i of `desc_mask_o` (lane i, bit 0 = lane 0) is 1 exactly when base + i < n.
- R6: Exactly ceil(n/32) descriptors are sent per launch, and none carries an all-zero mask.
- R7: While `desc_valid_o` is high and `desc_ready_i` is low, valid stays high and every descriptor field holds its value into the next cycle.
- R8: `done_o` is high for exactly one cycle, the cycle after the edge that accepts the last descriptor, and `desc_valid_o` is low in that cycle.
- R9: With n = 0, no descriptor is sent and `done_o` is high in the cycle right after the start edge.
- R10: A start seen outside IDLE (during ISSUE or FINISH) is ignored. The running launch keeps its count, block total and descriptor stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, acted on only in IDLE |
| n_i | input | CNT_W | Element count, sampled with the start |
| num_blocks_o | output | CNT_W-9+1 | Blocks needed by the latched launch |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Dispatcher accepts descriptor |
| desc_block_o | output | CNT_W-9+1 | Block number of the warp |
| desc_warp_o | output | 4 | Warp number inside the block |
| desc_base_o | output | CNT_W | Global index of lane 0 |
| desc_mask_o | output | 32 | Active-lane mask, bit i = lane i |
| done_o | output | 1 | One-cycle end-of-launch pulse |

## Verification
The sweep picks counts around every boundary: 0, 1, 31, 32, 33, one short of a block, exactly a block, one past it, and several-block sizes with ragged tails. A design that rounds the block count down, or stops one warp early, would drop the tail warp. One that does not stop at the last active warp would send an empty-mask warp. Both show up as a wrong descriptor count or a wrong mask. The ready input is driven both held high and with a pseudo-random pattern, so a cursor that moves without a handshake, or a descriptor that changes while stalled, shows up as a field mismatch. A start pulse with a different count is injected in the middle of long launches. A machine that restarted on it would produce a wrong block total or reset the descriptor stream.

// File: rtl/kl_pkg.sv
package kl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ISSUE  = 2'd1,
        SEQ_FINISH = 2'd2
    } seq_state_t;

endpackage

// File: rtl/kl_block_count.sv
module kl_block_count #(
    parameter int CNT_W   = 20,
    parameter int BLK_LOG = 9,
    localparam int BLK_W  = CNT_W - BLK_LOG + 1
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [BLK_W-1:0] blocks_o
);

    localparam int BLK_SIZE = 1 << BLK_LOG;

    // Round up: add one block minus one, then drop the in-block bits.
    always_comb begin
        blocks_o = BLK_W'(({1'b0, count_i} + (CNT_W+1)'(BLK_SIZE - 1)) >> BLK_LOG);
    end

endmodule

// File: rtl/kl_warp_cursor.sv
module kl_warp_cursor #(
    parameter int CNT_W    = 20,
    parameter int BLK_LOG  = 9,
    parameter int WARP_LOG = 5,
    localparam int BLK_W   = CNT_W - BLK_LOG + 1,
    localparam int WIDX_W  = BLK_LOG - WARP_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [BLK_W-1:0]  block_o,
    output logic [WIDX_W-1:0] warp_o,
    output logic [CNT_W-1:0]  base_o
);

    localparam int LANES = 1 << WARP_LOG;

    logic [BLK_W-1:0]  block_q;
    logic [WIDX_W-1:0] warp_q;
    logic [CNT_W-1:0]  base_q;
    logic              wrap_block;

    assign wrap_block = (warp_q == {WIDX_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            block_q <= '0;
            warp_q  <= '0;
            base_q  <= '0;
        end else if (clear_i) begin
            block_q <= '0;
            warp_q  <= '0;
            base_q  <= '0;
        end else if (step_i) begin
            base_q <= base_q + CNT_W'(LANES);
            if (wrap_block) begin
                warp_q  <= '0;
                block_q <= block_q + BLK_W'(1);
            end else begin
                warp_q <= warp_q + WIDX_W'(1);
            end
        end
    end

    assign block_o = block_q;
    assign warp_o  = warp_q;
    assign base_o  = base_q;

endmodule

// File: rtl/kl_lane_mask.sv
module kl_lane_mask #(
    parameter int CNT_W    = 20,
    parameter int WARP_LOG = 5,
    localparam int LANES   = 1 << WARP_LOG
) (
    input  logic [CNT_W-1:0] remain_i,
    output logic [LANES-1:0] mask_o,
    output logic             final_o
);

    // Lane i is live when more than i elements remain past the warp base.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask_o[i] = (remain_i > CNT_W'(i));
    end

    // No element left beyond this warp: it is the last one to send.
    assign final_o = (remain_i <= CNT_W'(LANES));

endmodule

// File: rtl/kl_warp_seq.sv
module kl_warp_seq
    import kl_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int BLK_LOG  = 9,
    parameter int WARP_LOG = 5,
    localparam int BLK_W   = CNT_W - BLK_LOG + 1,
    localparam int WIDX_W  = BLK_LOG - WARP_LOG,
    localparam int LANES   = 1 << WARP_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  n_i,
    output logic [BLK_W-1:0]  num_blocks_o,
    output logic              desc_valid_o,
    input  logic              desc_ready_i,
    output logic [BLK_W-1:0]  desc_block_o,
    output logic [WIDX_W-1:0] desc_warp_o,
    output logic [CNT_W-1:0]  desc_base_o,
    output logic [LANES-1:0]  desc_mask_o,
    output logic              done_o
);

    seq_state_t state_q, state_d;

    logic [CNT_W-1:0] count_q;
    logic [BLK_W-1:0] blocks_q;
    logic [BLK_W-1:0] blocks_calc;
    logic [CNT_W-1:0] remain;
    logic             final_warp;
    logic             accept;
    logic             load;
    logic             step;
    logic             clear;

    kl_block_count #(
        .CNT_W   (CNT_W),
        .BLK_LOG (BLK_LOG)
    ) u_blocks (
        .count_i  (n_i),
        .blocks_o (blocks_calc)
    );

    kl_warp_cursor #(
        .CNT_W    (CNT_W),
        .BLK_LOG  (BLK_LOG),
        .WARP_LOG (WARP_LOG)
    ) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .step_i  (step),
        .block_o (desc_block_o),
        .warp_o  (desc_warp_o),
        .base_o  (desc_base_o)
    );

    assign remain = count_q - desc_base_o;

    kl_lane_mask #(
        .CNT_W    (CNT_W),
        .WARP_LOG (WARP_LOG)
    ) u_mask (
        .remain_i (remain),
        .mask_o   (desc_mask_o),
        .final_o  (final_warp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Launch parameters, captured only on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            blocks_q <= '0;
        end else if (load) begin
            count_q  <= n_i;
            blocks_q <= blocks_calc;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    state_d = (n_i == '0) ? SEQ_FINISH : SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: begin
                if (accept && final_warp) begin
                    state_d = SEQ_FINISH;
                end
            end
            SEQ_FINISH: begin
                state_d = SEQ_IDLE;
            end
            default: begin
                state_d = SEQ_IDLE;
            end
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        desc_valid_o = 1'b0;
        done_o       = 1'b0;
        load         = 1'b0;
        clear        = 1'b0;
        step         = 1'b0;
        accept       = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                load  = start_i;
                clear = start_i;
            end
            SEQ_ISSUE: begin
                desc_valid_o = 1'b1;
                accept       = desc_ready_i;
                step         = desc_ready_i && !final_warp;
            end
            SEQ_FINISH: begin
                done_o = 1'b1;
            end
            default: begin
                done_o = 1'b0;
            end
        endcase
    end

    assign num_blocks_o = blocks_q;

endmodule

// File: rtl/kl_warp_seq_chk.sv
module kl_warp_seq_chk #(
    parameter int CNT_W    = 20,
    parameter int BLK_LOG  = 9,
    parameter int WARP_LOG = 5,
    localparam int BLK_W   = CNT_W - BLK_LOG + 1,
    localparam int WIDX_W  = BLK_LOG - WARP_LOG,
    localparam int LANES   = 1 << WARP_LOG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic              ready,
    input logic              done,
    input logic [BLK_W-1:0]  block,
    input logic [WIDX_W-1:0] warp,
    input logic [CNT_W-1:0]  base,
    input logic [LANES-1:0]  mask
);

    // R7
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(block) && $stable(warp)
                               && $stable(base) && $stable(mask)));

    // R4
    base_matches_ids_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (base == CNT_W'({block, warp, {WARP_LOG{1'b0}}})));

    // R6
    mask_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (mask != '0));

    // R5
    mask_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((mask & (mask + LANES'(1))) == '0));

    // R8
    done_without_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid);

    // R8
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> done);

endmodule

bind kl_warp_seq kl_warp_seq_chk #(
    .CNT_W    (CNT_W),
    .BLK_LOG  (BLK_LOG),
    .WARP_LOG (WARP_LOG)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (desc_valid_o),
    .ready (desc_ready_i),
    .done  (done_o),
    .block (desc_block_o),
    .warp  (desc_warp_o),
    .base  (desc_base_o),
    .mask  (desc_mask_o)
);

// File: tb/kl_warp_seq_bench.sv
module kl_warp_seq_bench;

    localparam int CNT_W  = 20;
    localparam int BLK_W  = CNT_W - 9 + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  n_i = '0;
    logic [BLK_W-1:0]  num_blocks_o;
    logic              desc_valid_o;
    logic              desc_ready_i = 1'b0;
    logic [BLK_W-1:0]  desc_block_o;
    logic [3:0]        desc_warp_o;
    logic [CNT_W-1:0]  desc_base_o;
    logic [31:0]       desc_mask_o;
    logic              done_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] lfsr = 8'hA5;

    always #10 clk = ~clk;

    kl_warp_seq u_kl_warp_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .n_i          (n_i),
        .num_blocks_o (num_blocks_o),
        .desc_valid_o (desc_valid_o),
        .desc_ready_i (desc_ready_i),
        .desc_block_o (desc_block_o),
        .desc_warp_o  (desc_warp_o),
        .desc_base_o  (desc_base_o),
        .desc_mask_o  (desc_mask_o),
        .done_o       (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One launch of n elements; rnd selects random backpressure, poke injects a start mid-launch
    task automatic run_launch(input int n, input bit rnd, input bit poke);
        int total;
        int exp_w;
        int iter;
        int blk_exp;
        longint rem;
        longint mexp;
        int mism;
        total = (n + 31) / 32;
        blk_exp = (n + 511) / 512;
        @(negedge clk);
        start_i = 1'b1;
        n_i = CNT_W'(n);
        desc_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        n_i = CNT_W'(n ^ 77);
        check(num_blocks_o == BLK_W'(blk_exp), "R2", "block count", num_blocks_o, blk_exp);
        if (n == 0) begin
            check(done_o == 1'b1 && desc_valid_o == 1'b0, "R9", "empty launch done", done_o, 1);
            @(negedge clk);
            check(done_o == 1'b0 && desc_valid_o == 1'b0, "R9", "no descriptor after empty", desc_valid_o, 0);
            return;
        end
        exp_w = 0;
        iter = 0;
        mism = 0;
        while (exp_w < total) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            desc_ready_i = rnd ? lfsr[0] : 1'b1;
            if (poke && iter == 3 && total > 5) begin
                start_i = 1'b1;
                n_i = CNT_W'(5);
            end else begin
                start_i = 1'b0;
            end
            rem = longint'(n) - longint'(exp_w) * 32;
            mexp = (rem >= 32) ? 64'hFFFF_FFFF : ((64'd1 << rem) - 1);
            if (!desc_valid_o) mism++;
            if (desc_block_o != BLK_W'(exp_w / 16)) mism++;
            if (desc_warp_o != 4'(exp_w % 16)) mism++;
            if (desc_base_o != CNT_W'(exp_w * 32)) mism++;
            if (longint'(desc_mask_o) != mexp) mism++;
            if (mism != 0) begin
                check(1'b0, "R3", $sformatf("desc k=%0d block", exp_w), desc_block_o, exp_w / 16);
                check(1'b0, "R4", "base", desc_base_o, exp_w * 32);
                check(1'b0, "R5", "mask", desc_mask_o, mexp);
                check(1'b0, "R7", "valid held", desc_valid_o, 1);
                return;
            end
            if (desc_ready_i) exp_w++;
            iter++;
            @(negedge clk);
            if (iter > 40000) begin
                check(1'b0, "R6", "stream too long", iter, total);
                return;
            end
        end
        start_i = 1'b0;
        check(1'b1, "R3", "order", exp_w, total);
        check(1'b1, "R4", "bases", exp_w, total);
        check(1'b1, "R5", "masks", exp_w, total);
        if (rnd) check(1'b1, "R7", "stall hold", exp_w, total);
        check(done_o == 1'b1 && desc_valid_o == 1'b0, "R6", "stream ends at ceil(n/32)", desc_valid_o, 0);
        check(done_o == 1'b1, "R8", "done after last accept", done_o, 1);
        if (poke && total > 5)
            check(num_blocks_o == BLK_W'(blk_exp), "R10", "start ignored while busy", num_blocks_o, blk_exp);
        @(negedge clk);
        check(done_o == 1'b0 && desc_valid_o == 1'b0, "R8", "done one cycle", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(desc_valid_o == 1'b0, "R1", "valid in reset", desc_valid_o, 0);
        check(done_o == 1'b0, "R1", "done in reset", done_o, 0);
        check(num_blocks_o == '0, "R1", "block count in reset", num_blocks_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(desc_valid_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset", desc_valid_o, 0);

        foreach (sizes_q[i]) begin
            run_launch(sizes_q[i], 1'b0, 1'b0);
            run_launch(sizes_q[i], 1'b1, 1'b1);
        end
        for (int n = 1; n <= 70; n++) begin
            run_launch(n, n[0], 1'b1);
        end

        // Start during the FINISH cycle is ignored (R10)
        @(negedge clk);
        start_i = 1'b1;
        n_i = CNT_W'(40);
        desc_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(done_o == 1'b1, "R8", "done for 40", done_o, 1);
        start_i = 1'b1;
        n_i = CNT_W'(100);
        @(negedge clk);
        start_i = 1'b0;
        check(desc_valid_o == 1'b0 && done_o == 1'b0, "R10", "start in finish ignored", desc_valid_o, 0);
        check(num_blocks_o == BLK_W'(1), "R10", "count kept after finish start", num_blocks_o, 1);

        finish_run();
    end

    int sizes_q[] = '{0, 1, 31, 32, 33, 511, 512, 513, 1000, 1024, 1500, 2049, 8192};

    initial begin
        repeat (180000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=timeout expected=finish");
        finish_run();
    end

endmodule